// File: doc/BRIEF.md
# Sampling Converter Bus Control Front End

This block is the digital control logic that places a sampling analog-to-digital converter on a microprocessor bus. The host drives five control lines: an active-high enable, an active-low select, a read/convert line, a byte-address line and a word/byte data-mode line. From these the block starts conversions of either full (12-bit) or short (8-bit) length. It raises a busy status for a fixed number of clocks, latches the result from the converter core when that time is up, and presents the latched result on a 12-line data bus.

The data bus is modelled as a data vector plus three separate drive enables: one for the whole word, one for the high byte and one for the low byte. A bench or a pad ring can therefore observe the bus without tri-state logic. In byte mode a byte is always placed on lines 11..4. Lines 3..0 are zero.

All control lines pass through a synchroniser before use, so a change on the pins shows up inside the block a fixed number of clocks later.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, busy is low, all three drive enables are low and the data vector is zero.
- R2: A conversion starts when the condition (enable high, select low, read/convert low) becomes true. It starts no matter which of the three lines completed the condition: a rising enable, a falling select or a falling read/convert.
- R3: Busy stays high for exactly CONV_LONG_CYC clocks for a full conversion and exactly CONV_SHORT_CYC clocks for a short conversion.
- R4: The byte-address line, as seen at the start, picks the length: 1 gives a short conversion and 0 gives a full conversion. When busy falls, the core result is latched.
- R5: After a short conversion, bits 3..0 of the latched result are zero.
- R6: While busy is high, no drive enable is asserted, even if the read condition holds.
- R7: A read needs enable high, select low, read/convert high and busy low. With the data-mode line at 1, the word enable is asserted, the data vector carries all 12 result bits, and the byte-address line has no effect.
- R8: With the data-mode line at 0 and the byte address at 0, the high-byte enable is asserted and the data vector is {result[11:4], 4'b0000}.
- R9: With the data-mode line at 0 and the byte address at 1, the low-byte enable is asserted and the data vector is {result[3:0], 8'b0}. This places four forced zeros below the nibble within the byte.
- R10: While enable is low or select is high, no conversion starts and no drive enable is asserted.
- R11: A start condition that appears while busy is high is ignored. That conversion keeps its length, and no second conversion follows it.
- R12: At most one of the three drive enables is asserted in any cycle, including while the byte-address line toggles during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | 1 = read, 0 = convert |
| baddr_i | input | 1 | Short-conversion select at start; byte select during byte reads |
| full_word_i | input | 1 | 1 = 12-bit word reads, 0 = byte reads |
| core_result_i | input | 12 | Result from the converter core |
| busy_o | output | 1 | Conversion status, high while converting |
| dout_o | output | 12 | Data bus value |
| oe_word_o | output | 1 | Drive enable for all 12 lines |
| oe_hi_o | output | 1 | Drive enable for the high byte on lines 11..4 |
| oe_lo_o | output | 1 | Drive enable for the low byte on lines 11..4 |

## Verification
The bench triggers starts through each of the three completing edges. A design that watched only one line would never raise busy for the other two. It measures the busy length for both conversion sizes, which exposes a swapped or off-by-one count. It also reads back short results, which shows whether the low nibble was zeroed. It holds read/convert high in the middle of a conversion and re-arms the start condition while busy; a faulty design would drive the bus early or chain a second conversion. During a byte read it toggles the byte address on every clock, where a broken select would enable both byte drivers at once.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    localparam int RES_W  = 12;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = RES_W - BYTE_W;

    typedef enum logic {
        LEN_FULL  = 1'b0,
        LEN_SHORT = 1'b1
    } conv_len_e;

    typedef enum logic [1:0] {
        DRV_NONE,
        DRV_WORD,
        DRV_HI,
        DRV_LO
    } drive_sel_e;

    typedef struct packed {
        logic ce;
        logic cs_n;
        logic rc;
        logic baddr;
        logic full;
    } bus_ctl_t;

    localparam int CTL_W = $bits(bus_ctl_t);

    // Idle pin levels: disabled, deselected, read side
    localparam bus_ctl_t CTL_IDLE = '{ce: 1'b0, cs_n: 1'b1, rc: 1'b1, baddr: 1'b0, full: 1'b0};

    function automatic logic [RES_W-1:0] store_value(input logic [RES_W-1:0] raw, input conv_len_e len);
        logic [RES_W-1:0] v;
        v = raw;
        if (len == LEN_SHORT) v[NIB_W-1:0] = '0;
        return v;
    endfunction

    function automatic logic [RES_W-1:0] bus_value(input drive_sel_e sel, input logic [RES_W-1:0] res);
        logic [RES_W-1:0] v;
        case (sel)
            DRV_WORD: v = res;
            DRV_HI:   v = {res[RES_W-1 -: BYTE_W], {NIB_W{1'b0}}};
            DRV_LO:   v = {res[NIB_W-1:0], {BYTE_W{1'b0}}};
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/adc_ctrl_sync.sv
module adc_ctrl_sync #(
    parameter int                 WIDTH   = 5,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_bus_pkg::*;
#(
    parameter int LONG_CYC  = 24,
    parameter int SHORT_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  conv_len_e        len_i,
    input  logic [RES_W-1:0] core_i,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o
);
    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int RUN_W   = $clog2(MAX_CYC + 2);

    typedef enum logic { ST_IDLE, ST_RUN } seq_state_e;

    seq_state_e       state_q;
    conv_len_e        len_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            len_q   <= LEN_FULL;
            cnt_q   <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_RUN;
                    len_q   <= len_i;
                    cnt_q   <= (len_i == LEN_SHORT) ? CNT_W'(SHORT_CYC - 1) : CNT_W'(LONG_CYC - 1);
                end
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                        res_q   <= store_value(core_i, len_q);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q == ST_RUN);
    assign result_o = res_q;

    // Independent measurement of each busy window
    logic [RUN_W-1:0] run_len_q;
    always_ff @(posedge clk) begin
        if (rst)         run_len_q <= '0;
        else if (busy_o) run_len_q <= run_len_q + 1'b1;
        else             run_len_q <= '0;
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_len_q == ((len_q == LEN_SHORT) ? RUN_W'(SHORT_CYC) : RUN_W'(LONG_CYC))));

    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && cnt_q != '0) |=> (busy_o && $stable(len_q)));

    // R5
    short_nib_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && len_q == LEN_SHORT) |-> (result_o[NIB_W-1:0] == '0));
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
    import adc_bus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  drive_sel_e       sel_i,
    input  logic [RES_W-1:0] result_i,
    output logic [RES_W-1:0] dout_o,
    output logic             oe_word_o,
    output logic             oe_hi_o,
    output logic             oe_lo_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o    <= '0;
            oe_word_o <= 1'b0;
            oe_hi_o   <= 1'b0;
            oe_lo_o   <= 1'b0;
        end else begin
            dout_o    <= bus_value(sel_i, result_i);
            oe_word_o <= (sel_i == DRV_WORD);
            oe_hi_o   <= (sel_i == DRV_HI);
            oe_lo_o   <= (sel_i == DRV_LO);
        end
    end

    // R12
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({oe_word_o, oe_hi_o, oe_lo_o}));

    // R9
    lo_pad_chk: assert property (@(posedge clk) disable iff (rst)
        oe_lo_o |-> (dout_o[BYTE_W-1:0] == '0));

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !(oe_word_o || oe_hi_o || oe_lo_o) |-> (dout_o == '0));
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int CONV_LONG_CYC  = 24,
    parameter int CONV_SHORT_CYC = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_i,
    input  logic        cs_n_i,
    input  logic        rc_i,
    input  logic        baddr_i,
    input  logic        full_word_i,
    input  logic [11:0] core_result_i,
    output logic        busy_o,
    output logic [11:0] dout_o,
    output logic        oe_word_o,
    output logic        oe_hi_o,
    output logic        oe_lo_o
);
    bus_ctl_t         pin_ctl;
    bus_ctl_t         ctl;
    logic [CTL_W-1:0] ctl_raw;
    logic             conv_cond;
    logic             conv_cond_q;
    logic             start;
    logic             busy;
    logic [RES_W-1:0] result;
    drive_sel_e       sel;

    assign pin_ctl = '{ce: ce_i, cs_n: cs_n_i, rc: rc_i, baddr: baddr_i, full: full_word_i};

    adc_ctrl_sync #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (pin_ctl),
        .q_o (ctl_raw)
    );

    assign ctl = bus_ctl_t'(ctl_raw);

    // Whichever line completes the condition produces the edge
    assign conv_cond = ctl.ce && !ctl.cs_n && !ctl.rc;

    always_ff @(posedge clk) begin
        if (rst) conv_cond_q <= 1'b0;
        else     conv_cond_q <= conv_cond;
    end

    assign start = conv_cond && !conv_cond_q && !busy;

    adc_conv_seq #(
        .LONG_CYC  (CONV_LONG_CYC),
        .SHORT_CYC (CONV_SHORT_CYC)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .len_i    (ctl.baddr ? LEN_SHORT : LEN_FULL),
        .core_i   (core_result_i),
        .busy_o   (busy),
        .result_o (result)
    );

    always_comb begin
        if (!(ctl.ce && !ctl.cs_n && ctl.rc && !busy)) sel = DRV_NONE;
        else if (ctl.full)                             sel = DRV_WORD;
        else if (ctl.baddr)                            sel = DRV_LO;
        else                                           sel = DRV_HI;
    end

    adc_out_fmt fmt_i (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (sel),
        .result_i  (result),
        .dout_o    (dout_o),
        .oe_word_o (oe_word_o),
        .oe_hi_o   (oe_hi_o),
        .oe_lo_o   (oe_lo_o)
    );

    assign busy_o = busy;

    // R6
    quiet_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_word_o || oe_hi_o || oe_lo_o) |-> !$past(busy));

    // R10
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.ce || ctl.cs_n) |=> !(oe_word_o || oe_hi_o || oe_lo_o));
endmodule

// File: tb/adc_bus_ctrl_tb_top.sv
module adc_bus_ctrl_tb_top;
    localparam int LCYC = 24;
    localparam int SCYC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0, cs_n = 1'b1, rc = 1'b1, baddr = 1'b0, full = 1'b0;
    logic [11:0] core = '0;
    logic        busy, oe_word, oe_hi, oe_lo;
    logic [11:0] dout;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_bus_ctrl #(.CONV_LONG_CYC(LCYC), .CONV_SHORT_CYC(SCYC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc), .baddr_i(baddr),
        .full_word_i(full), .core_result_i(core), .busy_o(busy), .dout_o(dout),
        .oe_word_o(oe_word), .oe_hi_o(oe_hi), .oe_lo_o(oe_lo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_store(input logic [11:0] r, input bit short_len);
        return short_len ? {r[11:4], 4'h0} : r;
    endfunction

    function automatic logic [14:0] exp_bus(input logic [11:0] s, input bit word, input bit addr);
        // {oe_word, oe_hi, oe_lo, dout}
        if (word)      return {3'b100, s};
        else if (addr) return {3'b001, s[3:0], 8'h00};
        else           return {3'b010, s[11:4], 4'h0};
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        ce = 1'b0; cs_n = 1'b1; rc = 1'b1;
        wait_n(5);
    endtask

    // kind 0: read/convert last, 1: select last, 2: enable last
    // act 1: raise read/convert mid-conversion, 2: re-arm start mid-conversion
    task automatic run_conv(input logic [11:0] r, input bit short_len, input int kind,
                            input int act, output int len);
        int wait_cnt = 0;
        core = r; baddr = short_len;
        case (kind)
            0: begin ce = 1'b1; cs_n = 1'b0; wait_n(3); rc = 1'b0; end
            1: begin ce = 1'b1; rc = 1'b0; wait_n(3); cs_n = 1'b0; end
            default: begin cs_n = 1'b0; rc = 1'b0; wait_n(3); ce = 1'b1; end
        endcase
        @(negedge clk);
        while (!busy && wait_cnt < 10) begin wait_cnt++; @(negedge clk); end
        len = 0;
        while (busy && len < 200) begin
            len++;
            if (act != 0 && len == 3) rc = 1'b1;
            if (act == 2 && len == 7) rc = 1'b0;
            if (act == 1 && len == 10)
                chk("R6 no drive while busy", {oe_word, oe_hi, oe_lo}, 3'b000);
            @(negedge clk);
        end
        if (act == 2) begin
            int extra = 0;
            for (int i = 0; i < 30; i++) begin
                if (busy) extra++;
                @(negedge clk);
            end
            chk("R11 no chained conversion", extra, 0);
        end
    endtask

    task automatic do_read(input logic [11:0] s, input bit word, input bit addr, input string req);
        logic [14:0] e;
        full = word; baddr = addr; ce = 1'b1; cs_n = 1'b0; rc = 1'b1;
        wait_n(4);
        e = exp_bus(s, word, addr);
        chk(req, {oe_word, oe_hi, oe_lo, dout}, e);
        go_idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int len;
        logic [11:0] r, s;
        void'($urandom(32'd2024));
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        chk("R1 reset bus", {busy, oe_word, oe_hi, oe_lo, dout}, 16'h0000);

        // R2/R3/R4: full conversion, read/convert last
        r = 12'hA5C;
        run_conv(r, 1'b0, 0, 0, len);
        chk("R3 full length", len, LCYC);
        go_idle();
        do_read(r, 1'b1, 1'b0, "R4 full result word");

        // R2 select last, short conversion R4/R5
        r = 12'h3E7;
        run_conv(r, 1'b1, 1, 0, len);
        chk("R3 short length", len, SCYC);
        go_idle();
        do_read(exp_store(r, 1'b1), 1'b1, 1'b0, "R5 short low nibble zero");

        // R2 enable last
        r = 12'hF0F;
        run_conv(r, 1'b0, 2, 0, len);
        chk("R2 enable-last start", len, LCYC);
        go_idle();
        do_read(r, 1'b1, 1'b1, "R7 word ignores byte address");
        do_read(r, 1'b0, 1'b0, "R8 high byte");
        do_read(r, 1'b0, 1'b1, "R9 low byte");

        // R6: read requested during conversion
        r = 12'h5A1;
        run_conv(r, 1'b0, 0, 1, len);
        chk("R6 length unchanged", len, LCYC);
        full = 1'b1; wait_n(4);
        chk("R6 drive after busy", {oe_word, oe_hi, oe_lo, dout}, {3'b100, r});
        go_idle();

        // R11: start re-armed during busy
        r = 12'h1C3;
        run_conv(r, 1'b1, 0, 2, len);
        chk("R11 length kept", len, SCYC);
        go_idle();

        // R10: disabled or deselected
        ce = 1'b0; cs_n = 1'b0; rc = 1'b1; wait_n(3); rc = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 12; i++) begin if (busy) seen++; @(negedge clk); end
            chk("R10 no start with enable low", seen, 0);
        end
        go_idle();
        ce = 1'b1; cs_n = 1'b1; rc = 1'b0; wait_n(3); rc = 1'b1; wait_n(4);
        chk("R10 deselected no drive", {busy, oe_word, oe_hi, oe_lo}, 4'b0000);
        go_idle();

        // R12: toggle byte address every clock during a byte read
        full = 1'b0; ce = 1'b1; cs_n = 1'b0; rc = 1'b1;
        for (int i = 0; i < 24; i++) begin
            baddr = ~baddr;
            @(negedge clk);
            chk("R12 single driver", {30'd0, oe_hi && oe_lo}, 0);
        end
        go_idle();

        // Random mix
        for (int n = 0; n < 40; n++) begin
            bit sh, wd, ad;
            int kd;
            r  = 12'($urandom());
            sh = 1'($urandom_range(1, 0));
            kd = $urandom_range(2, 0);
            wd = 1'($urandom_range(1, 0));
            ad = 1'($urandom_range(1, 0));
            run_conv(r, sh, kd, 0, len);
            chk(sh ? "R3 random short length" : "R3 random full length", len, sh ? SCYC : LCYC);
            go_idle();
            s = exp_store(r, sh);
            do_read(s, wd, ad, wd ? "R7 random word" : (ad ? "R9 random low" : "R8 random high"));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule